// File: doc/BRIEF.md
# Evaluation Stack Unit with Register-Held Top Element

This block is the operand stack datapath of a 16-bit stack machine. The topmost stack element is held in a dedicated register. Every element below it lives in a word-wide RAM of 1024 entries, addressed by a stack pointer. The pointer moves down before a write and up after a read. Because of this arrangement, each stack command completes in one clock cycle: a binary operation reads its second operand from the RAM in the same cycle that it writes the result into the top register.

A controller issues one command per cycle, together with a 16-bit operand word. The commands are: push a value, pop, add the top two elements, add the operand to the top, test the top two elements for equality, and overwrite the top. The unit reports the top element and the pointer. Two sticky flags mark an attempted push onto a full stack and an attempted pop or binary operation on an empty one. A faulting command changes no other state. Arithmetic wraps modulo 2^16.

Top module: `evs_unit`

## Requirements
- R1: After reset (rst_n low, asynchronous) the pointer reads 1024, the top register reads 0 and both flags read 0.
- R2: Command code 1 (push), when the pointer is not 0: the pointer drops by one, the old top value is stored in the RAM at the new pointer, and the operand becomes the top value. The result is visible after the next rising edge.
- R3: Command code 2 (pop), when the pointer is not 1024: the top register takes the RAM word at the pointer, and the pointer then rises by one. Values come back in last-in, first-out order.
- R4: Command code 3 (add), when the pointer is not 1024: the top register becomes top plus the RAM word at the pointer, modulo 2^16, and the pointer rises by one.
- R5: Command code 4 (add operand): the top register becomes top plus the operand, modulo 2^16. The pointer does not change, and no flag is raised.
- R6: Command code 5 (equality), when the pointer is not 1024: the top register becomes 1 if top equals the RAM word at the pointer, and 0 otherwise. The pointer rises by one.
- R7: Command code 6 (load): the top register takes the operand, and the pointer does not change.
- R8: A push when the pointer is 0 sets the overflow flag. The flag stays set until reset, and the command changes neither the pointer nor the top register.
- R9: A pop, add or equality command when the pointer is 1024 sets the underflow flag. The flag stays set until reset, and the command changes neither the pointer nor the top register.
- R10: Command codes 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code for this cycle |
| opnd_i | input | 16 | Operand word for push, load and add-operand |
| tos_o | output | 16 | Current top-of-stack register |
| sp_o | output | 11 | Stack pointer, 1024 means empty |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
On every cycle, the assertions check the following: pointer movement for push and pull commands, a frozen pointer for commands that do not touch the RAM, flag stickiness, the freezing effect of a faulting command, the sum that add produces, the 0/1 result of equality, and the load of the operand. Only the bench scenarios can show what the RAM holds. This includes last-in, first-out return order, the value left in the lowest entry after a stack is filled to the limit, wrap-around of both adds, and flags that survive later valid commands until a reset clears them.

// File: rtl/evs_pkg.sv
package evs_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_ADD  = 3'd3,
      OP_ADDK = 3'd4,
      OP_EQ   = 3'd5,
      OP_LOAD = 3'd6,
      OP_RSV  = 3'd7
   } evs_op_e;
endpackage

// File: rtl/evs_ram.sv
module evs_ram #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   generate
      if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("evs_ram: DEPTH must be a power of two");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("evs_ram: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // read is combinational so a pull command completes in one cycle
   assign rdata = mem[raddr];
endmodule

// File: rtl/evs_ptr.sv
module evs_ptr
   import evs_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int PTR_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evs_op_e          op,
   output logic [PTR_W-1:0] sp,
   output logic             push_ok,
   output logic             pull_ok,
   output logic             ovf,
   output logic             udf
);
   localparam logic [PTR_W-1:0] SP_EMPTY = PTR_W'(DEPTH);

   logic is_push, is_pull, full, empty;

   assign is_push = (op == OP_PUSH);
   assign is_pull = (op == OP_POP) || (op == OP_ADD) || (op == OP_EQ);
   assign full    = (sp == '0);
   assign empty   = (sp == SP_EMPTY);
   assign push_ok = is_push && !full;
   assign pull_ok = is_pull && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp  <= SP_EMPTY;
         ovf <= 1'b0;
         udf <= 1'b0;
      end else begin
         if (push_ok)      sp <= sp - PTR_W'(1);
         else if (pull_ok) sp <= sp + PTR_W'(1);
         if (is_push && full)  ovf <= 1'b1;
         if (is_pull && empty) udf <= 1'b1;
      end
   end

   a_r2_push_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> sp == $past(sp) - PTR_W'(1));
   a_r3_pull_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
      pull_ok |=> sp == $past(sp) + PTR_W'(1));
   a_r5_still_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_push && !is_pull) |=> $stable(sp));
   a_r8_ovf_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (is_push && full) |=> ovf && $stable(sp));
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   a_r9_udf_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pull && empty) |=> udf && $stable(sp));
   a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      udf |=> udf);
endmodule

// File: rtl/evs_alu.sv
module evs_alu
   import evs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  evs_op_e           op,
   input  logic [DATA_W-1:0] tos,
   input  logic [DATA_W-1:0] nos,
   input  logic [DATA_W-1:0] opnd,
   input  logic              push_ok,
   input  logic              pull_ok,
   output logic [DATA_W-1:0] tos_nxt
);
   always_comb begin
      tos_nxt = tos;
      unique case (op)
         OP_PUSH: if (push_ok) tos_nxt = opnd;
         OP_POP:  if (pull_ok) tos_nxt = nos;
         OP_ADD:  if (pull_ok) tos_nxt = tos + nos;
         OP_ADDK: tos_nxt = tos + opnd;
         OP_EQ:   if (pull_ok) tos_nxt = DATA_W'(tos == nos);
         OP_LOAD: tos_nxt = opnd;
         OP_NOP, OP_RSV: tos_nxt = tos;
         default: tos_nxt = tos;
      endcase
   end
endmodule

// File: rtl/evs_unit.sv
module evs_unit
   import evs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int PTR_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_i,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [DATA_W-1:0] tos_o,
   output logic [PTR_W-1:0]  sp_o,
   output logic              ovf_o,
   output logic              udf_o
);
   evs_op_e           op;
   logic [PTR_W-1:0]  sp;
   logic              push_ok, pull_ok;
   logic [DATA_W-1:0] tos_q, tos_nxt, nos;

   assign op = evs_op_e'(cmd_i);

   evs_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .op(op), .sp(sp),
      .push_ok(push_ok), .pull_ok(pull_ok), .ovf(ovf_o), .udf(udf_o)
   );

   evs_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .we(push_ok),
      .waddr(ADDR_W'(sp - PTR_W'(1))),
      .wdata(tos_q),
      .raddr(sp[ADDR_W-1:0]),
      .rdata(nos)
   );

   evs_alu #(.DATA_W(DATA_W)) u_alu (
      .op(op), .tos(tos_q), .nos(nos), .opnd(opnd_i),
      .push_ok(push_ok), .pull_ok(pull_ok), .tos_nxt(tos_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tos_q <= '0;
      else        tos_q <= tos_nxt;
   end

   assign tos_o = tos_q;
   assign sp_o  = sp;

   a_r4_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD && pull_ok) |=> tos_q == DATA_W'($past(tos_q) + $past(nos)));
   a_r6_eq_bool: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_EQ && pull_ok) |=> tos_q <= DATA_W'(1));
   a_r7_load_opnd: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD) |=> tos_q == $past(opnd_i));
   a_r9_udf_keeps_tos: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_POP || op == OP_ADD || op == OP_EQ) && !pull_ok) |=> $stable(tos_q));
   a_r10_idle_keeps_tos: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP || op == OP_RSV) |=> $stable(tos_q));
endmodule

// File: tb/sim_evs_unit.sv
`timescale 1ns/1ps
module sim_evs_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [15:0] opnd = 16'd0;
   logic [15:0] tos;
   logic [10:0] sp;
   logic        ovf, udf;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evs_unit u0 (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .opnd_i(opnd),
      .tos_o(tos), .sp_o(sp), .ovf_o(ovf), .udf_o(udf)
   );

   // {cmd, opnd, expected tos, expected sp, expected ovf, expected udf}
   localparam int NV = 17;
   localparam logic [47:0] VEC [NV] = '{
      {3'd1, 16'h0005, 16'h0005, 11'd1023, 2'b00},  // R2 push
      {3'd1, 16'h0007, 16'h0007, 11'd1022, 2'b00},  // R2 push
      {3'd3, 16'h0000, 16'h000C, 11'd1023, 2'b00},  // R4 add
      {3'd1, 16'hFFFF, 16'hFFFF, 11'd1022, 2'b00},  // R2 push
      {3'd3, 16'h0000, 16'h000B, 11'd1023, 2'b00},  // R4 add wraps
      {3'd4, 16'h0010, 16'h001B, 11'd1023, 2'b00},  // R5 add operand
      {3'd1, 16'h001B, 16'h001B, 11'd1022, 2'b00},  // R2 push
      {3'd5, 16'h0000, 16'h0001, 11'd1023, 2'b00},  // R6 equal
      {3'd1, 16'h0003, 16'h0003, 11'd1022, 2'b00},  // R2 push
      {3'd5, 16'h0000, 16'h0000, 11'd1023, 2'b00},  // R6 not equal
      {3'd6, 16'h1234, 16'h1234, 11'd1023, 2'b00},  // R7 load
      {3'd0, 16'hBEEF, 16'h1234, 11'd1023, 2'b00},  // R10 code 0
      {3'd4, 16'hEDCC, 16'h0000, 11'd1023, 2'b00},  // R5 wraps
      {3'd2, 16'h0000, 16'h0000, 11'd1024, 2'b00},  // R3 pop
      {3'd2, 16'h0000, 16'h0000, 11'd1024, 2'b01},  // R9 pop on empty
      {3'd3, 16'h0000, 16'h0000, 11'd1024, 2'b01},  // R9 add on empty
      {3'd1, 16'h0009, 16'h0009, 11'd1023, 2'b01}   // R9 flag sticky
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] c, input logic [15:0] o);
      cmd  = c;
      opnd = o;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cmd = 3'd0;
      repeat (2) @(negedge clk);
      chk("R1 tos", tos, 16'h0000);
      chk("R1 sp", 16'(sp), 16'd1024);
      chk("R1 flags", {14'd0, ovf, udf}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][47:45], VEC[i][44:29]);
         chk($sformatf("R2-vector %0d tos", i), tos, VEC[i][28:13]);
         chk($sformatf("R3 vector %0d sp", i), 16'(sp), 16'(VEC[i][12:2]));
         chk($sformatf("R8 vector %0d flags", i), {14'd0, ovf, udf}, {14'd0, VEC[i][1:0]});
      end

      // R1: reset clears sticky flag
      do_reset();

      // R10: code 7 changes nothing
      step(3'd1, 16'h00AA);
      step(3'd7, 16'h5555);
      chk("R10 code 7 tos", tos, 16'h00AA);
      chk("R10 code 7 sp", 16'(sp), 16'd1023);

      // R3: last-in first-out order
      step(3'd1, 16'h0011);
      step(3'd1, 16'h0022);
      step(3'd2, 16'h0000);
      chk("R3 lifo first", tos, 16'h0011);
      step(3'd2, 16'h0000);
      chk("R3 lifo second", tos, 16'h00AA);
      step(3'd2, 16'h0000);
      chk("R3 lifo last", tos, 16'h0000);
      chk("R3 lifo sp", 16'(sp), 16'd1024);
      chk("R9 no flag yet", {15'd0, udf}, 16'd0);

      // R8: fill to pointer 0 and overflow
      do_reset();
      for (int i = 0; i < 1024; i++) step(3'd1, 16'(i));
      chk("R2 full sp", 16'(sp), 16'd0);
      chk("R2 full tos", tos, 16'd1023);
      chk("R8 no flag at full", {15'd0, ovf}, 16'd0);
      step(3'd1, 16'hAAAA);
      chk("R8 ovf set", {15'd0, ovf}, 16'd1);
      chk("R8 tos kept", tos, 16'd1023);
      chk("R8 sp kept", 16'(sp), 16'd0);
      step(3'd2, 16'h0000);
      chk("R8 lowest entry", tos, 16'd1022);
      chk("R8 ovf sticky", {15'd0, ovf}, 16'd1);
      chk("R3 sp after pop", 16'(sp), 16'd1);
      // R7: load with full-range operand
      step(3'd6, 16'h8001);
      chk("R7 load", tos, 16'h8001);
      chk("R7 sp kept", 16'(sp), 16'd1);

      do_reset();
      // R6: equality on empty stack faults
      step(3'd5, 16'h0000);
      chk("R6 eq empty udf", {15'd0, udf}, 16'd1);
      chk("R6 eq empty tos", tos, 16'h0000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule